// File: doc/BRIEF.md
# MSI Snooping Coherence Controller

This block keeps one direct-mapped, write-back cache coherent with its peers on a shared atomic bus, using three line states: Invalid, Shared and Modified. The processor side issues one word read or write at a time. On a miss or on a write to a line it does not own, the controller puts a line-sized transaction on the bus. A clean read fetch yields a Shared line. A fetch with intent to modify yields a Modified line, and the written word is merged into the loaded line. A Modified victim is written back before its replacement is fetched.

The bus side is also watched. Every peer read or read-for-ownership is checked against the local tags. A Modified copy is supplied on the flush path in the same cycle, and the local line is downgraded or dropped. The environment grants the controller's request with a one-cycle completion strobe. That strobe is never raised in a cycle that carries a peer snoop.

Addresses on the processor side are word addresses. A line address is the word address with the word-offset bits removed. Word k of a line occupies bits [k*DATA_W +: DATA_W] of every line-wide bus.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, cpu_req_ready is high, no bus request is raised, and the first read of any address issues a clean fetch.
- R2: A read that hits a Shared or Modified line raises no bus request and returns the stored word with cpu_resp_valid one cycle after acceptance.
- R3: A read to an Invalid line, or to a line holding another tag, issues command 1 (clean fetch) with the requested line address. The line becomes Shared, and the word is returned one cycle after bus_done.
- R4: A write to a Shared or Invalid line issues command 2 (fetch for ownership), even when the line is already Shared locally. The whole line is loaded, the written word is merged, and the line becomes Modified.
- R5: A write that hits a Modified line raises no bus request, updates the word, and responds one cycle after acceptance.
- R6: A snooped command 1 that matches a Modified line raises snp_flush with the full line in the same cycle, and the line becomes Shared.
- R7: A snooped command 2 that matches a Modified line raises snp_flush with the full line, and the line becomes Invalid.
- R8: A snooped command 2 that matches a Shared line makes it Invalid without a flush, and a snooped command 1 leaves it Shared. Snoops that miss, and snooped command 3, cause no flush and no state change.
- R9: A miss whose victim is Modified with another tag first issues command 3 (write back) with the victim's line address and data, then the fetch. A Shared victim is dropped without a write back.
- R10: If the victim leaves Modified through a snoop before the write back is granted, the write back is withdrawn and only the fetch is issued.
- R11: cpu_req_ready is low in every cycle with snp_valid high. A fetch request keeps its command and address until bus_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request accepted this cycle when valid |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Write word |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_rdata | output | DATA_W | Read word (write word for writes) |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_cmd | output | 2 | 1 clean fetch, 2 fetch for ownership, 3 write back |
| bus_req_addr | output | LADDR_W | Line address of the request |
| bus_req_data | output | LINE_W | Line data for a write back |
| bus_done | input | 1 | Request granted and completed this cycle |
| bus_rdata | input | LINE_W | Line returned for a fetch, valid with bus_done |
| snp_valid | input | 1 | Peer transaction observed |
| snp_cmd | input | 2 | Peer command, same encoding |
| snp_addr | input | LADDR_W | Peer line address |
| snp_flush | output | 1 | This cache supplies the dirty line |
| snp_flush_data | output | LINE_W | Supplied line |

## Verification
Random word reads and writes over three tags that alias into a few sets produce hits, clean misses, upgrades from Shared and conflict evictions. Comparing the bus commands with a bench model separates the Shared-to-Modified upgrade from a silent write, and a dirty victim from a clean one. Peer snoops of all three commands, aimed at lines in each local state, tell a flush-and-downgrade apart from a flush-and-drop and from an ignored snoop. Snoops injected while a write back or fetch is still waiting show whether the write back is withdrawn once the victim is no longer dirty, and whether a line invalidated during an upgrade still ends up Modified with the merged word.

// File: rtl/msi_pkg.sv
package msi_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_MOD = 2'd2
  } line_state_t;

  typedef enum logic [1:0] {
    BC_NONE = 2'd0,
    BC_RD   = 2'd1,
    BC_RDX  = 2'd2,
    BC_WB   = 2'd3
  } bus_cmd_t;

  // processor access served locally without a bus transaction
  function automatic logic cpu_hit(line_state_t st, logic is_write);
    return (st == LS_MOD) || ((st == LS_SHR) && !is_write);
  endfunction

  function automatic bus_cmd_t fetch_cmd(logic is_write);
    return is_write ? BC_RDX : BC_RD;
  endfunction

  function automatic line_state_t fetch_state(logic is_write);
    return is_write ? LS_MOD : LS_SHR;
  endfunction

  // state after a peer transaction that matches this line
  function automatic line_state_t snoop_next(line_state_t st, bus_cmd_t cmd);
    line_state_t nxt;
    nxt = st;
    if (cmd == BC_RDX) nxt = LS_INV;
    else if (cmd == BC_RD && st == LS_MOD) nxt = LS_SHR;
    return nxt;
  endfunction

  function automatic logic snoop_flush(line_state_t st, bus_cmd_t cmd);
    return (st == LS_MOD) && ((cmd == BC_RD) || (cmd == BC_RDX));
  endfunction

endpackage

// File: rtl/msi_tag_store.sv
module msi_tag_store
  import msi_pkg::*;
#(
  parameter int SETS  = 8,
  parameter int TAG_W = 7,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] cpu_idx,
  output line_state_t      cpu_state,
  output logic [TAG_W-1:0] cpu_tag,
  input  logic [IDX_W-1:0] snp_idx,
  output line_state_t      snp_state,
  output logic [TAG_W-1:0] snp_tag,
  input  logic             ctl_we,
  input  logic [TAG_W-1:0] ctl_tag,
  input  line_state_t      ctl_state,
  input  logic             snp_we,
  input  line_state_t      snp_state_nxt
);

  line_state_t      st_q  [SETS];
  logic [TAG_W-1:0] tag_q [SETS];

  assign cpu_state = st_q[cpu_idx];
  assign cpu_tag   = tag_q[cpu_idx];
  assign snp_state = st_q[snp_idx];
  assign snp_tag   = tag_q[snp_idx];

  // controller writes use the lookup index; they never share a cycle with a snoop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        st_q[s]  <= LS_INV;
        tag_q[s] <= '0;
      end
    end else if (ctl_we) begin
      st_q[cpu_idx]  <= ctl_state;
      tag_q[cpu_idx] <= ctl_tag;
    end else if (snp_we) begin
      st_q[snp_idx] <= snp_state_nxt;
    end
  end

endmodule

// File: rtl/msi_data_store.sv
module msi_data_store #(
  parameter int SETS   = 8,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2(SETS),
  localparam int OFF_W  = $clog2(WORDS),
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  cpu_idx,
  output logic [LINE_W-1:0] cpu_line,
  input  logic [IDX_W-1:0]  snp_idx,
  output logic [LINE_W-1:0] snp_line,
  input  logic              line_we,
  input  logic [LINE_W-1:0] line_data,
  input  logic              word_we,
  input  logic [OFF_W-1:0]  word_off,
  input  logic [DATA_W-1:0] word_data
);

  logic [LINE_W-1:0] mem_q [SETS];

  assign cpu_line = mem_q[cpu_idx];
  assign snp_line = mem_q[snp_idx];

  always_ff @(posedge clk) begin
    if (line_we) mem_q[cpu_idx] <= line_data;
    else if (word_we) mem_q[cpu_idx][word_off*DATA_W +: DATA_W] <= word_data;
  end

endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
#(
  parameter int TAG_W  = 7,
  parameter int LINE_W = 128
) (
  input  logic              snp_valid,
  input  bus_cmd_t          snp_cmd,
  input  logic [TAG_W-1:0]  snp_tag_in,
  input  line_state_t       line_state,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [LINE_W-1:0] line_data,
  output logic              snp_hit,
  output line_state_t       snp_state_nxt,
  output logic              flush,
  output logic [LINE_W-1:0] flush_data
);

  assign snp_hit       = snp_valid && (line_state != LS_INV) && (line_tag == snp_tag_in);
  assign snp_state_nxt = snoop_next(line_state, snp_cmd);
  assign flush         = snp_hit && snoop_flush(line_state, snp_cmd);
  assign flush_data    = line_data;

endmodule

// File: rtl/msi_ctrl_fsm.sv
module msi_ctrl_fsm
  import msi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORDS  = 4,
  parameter int SETS   = 8,
  parameter int DATA_W = 32,
  localparam int OFF_W   = $clog2(WORDS),
  localparam int IDX_W   = $clog2(SETS),
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W,
  localparam int LADDR_W = ADDR_W - OFF_W,
  localparam int LINE_W  = WORDS * DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req_valid,
  input  logic               cpu_req_write,
  input  logic [ADDR_W-1:0]  cpu_req_addr,
  input  logic [DATA_W-1:0]  cpu_req_wdata,
  input  logic               snp_valid,
  output logic               cpu_req_ready,
  output logic               cpu_resp_valid,
  output logic [DATA_W-1:0]  cpu_resp_rdata,
  output logic [IDX_W-1:0]   lk_idx,
  input  line_state_t        lk_state,
  input  logic [TAG_W-1:0]   lk_tag,
  input  logic [LINE_W-1:0]  lk_line,
  output logic               tag_we,
  output logic [TAG_W-1:0]   tag_wr_tag,
  output line_state_t        tag_wr_state,
  output logic               line_we,
  output logic [LINE_W-1:0]  line_data,
  output logic               word_we,
  output logic [OFF_W-1:0]   word_off,
  output logic [DATA_W-1:0]  word_data,
  output logic               bus_req_valid,
  output bus_cmd_t           bus_req_cmd,
  output logic [LADDR_W-1:0] bus_req_addr,
  output logic [LINE_W-1:0]  bus_req_data,
  input  logic               bus_done,
  input  logic [LINE_W-1:0]  bus_rdata,
  output logic               ev_hit,
  output logic               ev_wb_wait,
  output logic               ev_fill_wait,
  output logic               ev_fill_done
);

  typedef enum logic [1:0] {FS_IDLE, FS_WB, FS_FILL} fsm_t;

  fsm_t              st_q;
  logic              r_write;
  logic [IDX_W-1:0]  r_idx;
  logic [TAG_W-1:0]  r_tag;
  logic [TAG_W-1:0]  r_vtag;
  logic [OFF_W-1:0]  r_off;
  logic [DATA_W-1:0] r_wdata;

  logic [IDX_W-1:0]  in_idx;
  logic [TAG_W-1:0]  in_tag;
  logic [OFF_W-1:0]  in_off;
  logic              accept;
  logic              victim_dirty;
  logic              wb_live;
  logic              wb_done;
  logic [LINE_W-1:0] fill_line;

  assign in_off = cpu_req_addr[OFF_W-1:0];
  assign in_idx = cpu_req_addr[OFF_W +: IDX_W];
  assign in_tag = cpu_req_addr[ADDR_W-1 -: TAG_W];

  assign lk_idx        = (st_q == FS_IDLE) ? in_idx : r_idx;
  assign cpu_req_ready = (st_q == FS_IDLE) && !snp_valid;
  assign accept        = cpu_req_ready && cpu_req_valid;
  assign ev_hit        = accept && (lk_tag == in_tag) && cpu_hit(lk_state, cpu_req_write);
  assign victim_dirty  = (lk_state == LS_MOD) && (lk_tag != in_tag);

  // write back stays requested only while the victim is still dirty
  assign wb_live      = (st_q == FS_WB) && (lk_state == LS_MOD) && (lk_tag == r_vtag);
  assign wb_done      = wb_live && bus_done;
  assign ev_wb_wait   = (st_q == FS_WB);
  assign ev_fill_wait = (st_q == FS_FILL);
  assign ev_fill_done = ev_fill_wait && bus_done;

  // merge the written word into the loaded line
  for (genvar w = 0; w < WORDS; w++) begin : g_merge
    assign fill_line[w*DATA_W +: DATA_W] =
      (r_write && (r_off == OFF_W'(w))) ? r_wdata : bus_rdata[w*DATA_W +: DATA_W];
  end

  assign bus_req_valid = wb_live || ev_fill_wait;
  assign bus_req_cmd   = ev_fill_wait ? fetch_cmd(r_write) : (wb_live ? BC_WB : BC_NONE);
  assign bus_req_addr  = ev_fill_wait ? {r_tag, r_idx} : {r_vtag, r_idx};
  assign bus_req_data  = lk_line;

  assign tag_we       = ev_fill_done || wb_done;
  assign tag_wr_tag   = ev_fill_done ? r_tag : r_vtag;
  assign tag_wr_state = ev_fill_done ? fetch_state(r_write) : LS_INV;
  assign line_we      = ev_fill_done;
  assign line_data    = fill_line;
  assign word_we      = ev_hit && cpu_req_write;
  assign word_off     = in_off;
  assign word_data    = cpu_req_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q           <= FS_IDLE;
      r_write        <= 1'b0;
      r_idx          <= '0;
      r_tag          <= '0;
      r_vtag         <= '0;
      r_off          <= '0;
      r_wdata        <= '0;
      cpu_resp_valid <= 1'b0;
      cpu_resp_rdata <= '0;
    end else begin
      cpu_resp_valid <= 1'b0;
      unique case (st_q)
        FS_IDLE: begin
          if (ev_hit) begin
            cpu_resp_valid <= 1'b1;
            cpu_resp_rdata <= cpu_req_write ? cpu_req_wdata
                                            : lk_line[in_off*DATA_W +: DATA_W];
          end else if (accept) begin
            r_write <= cpu_req_write;
            r_idx   <= in_idx;
            r_tag   <= in_tag;
            r_vtag  <= lk_tag;
            r_off   <= in_off;
            r_wdata <= cpu_req_wdata;
            st_q    <= victim_dirty ? FS_WB : FS_FILL;
          end
        end
        FS_WB: begin
          if (!wb_live || bus_done) st_q <= FS_FILL;
        end
        FS_FILL: begin
          if (bus_done) begin
            cpu_resp_valid <= 1'b1;
            cpu_resp_rdata <= r_write ? r_wdata : bus_rdata[r_off*DATA_W +: DATA_W];
            st_q           <= FS_IDLE;
          end
        end
        default: st_q <= FS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORDS  = 4,
  parameter int SETS   = 8,
  parameter int DATA_W = 32,
  localparam int OFF_W   = $clog2(WORDS),
  localparam int IDX_W   = $clog2(SETS),
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W,
  localparam int LADDR_W = ADDR_W - OFF_W,
  localparam int LINE_W  = WORDS * DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req_valid,
  output logic               cpu_req_ready,
  input  logic               cpu_req_write,
  input  logic [ADDR_W-1:0]  cpu_req_addr,
  input  logic [DATA_W-1:0]  cpu_req_wdata,
  output logic               cpu_resp_valid,
  output logic [DATA_W-1:0]  cpu_resp_rdata,
  output logic               bus_req_valid,
  output logic [1:0]         bus_req_cmd,
  output logic [LADDR_W-1:0] bus_req_addr,
  output logic [LINE_W-1:0]  bus_req_data,
  input  logic               bus_done,
  input  logic [LINE_W-1:0]  bus_rdata,
  input  logic               snp_valid,
  input  logic [1:0]         snp_cmd,
  input  logic [LADDR_W-1:0] snp_addr,
  output logic               snp_flush,
  output logic [LINE_W-1:0]  snp_flush_data
);

  logic [IDX_W-1:0]  lk_idx;
  line_state_t       lk_state;
  logic [TAG_W-1:0]  lk_tag;
  logic [LINE_W-1:0] lk_line;
  logic [IDX_W-1:0]  snp_idx;
  logic [TAG_W-1:0]  snp_tag_in;
  line_state_t       snp_state;
  logic [TAG_W-1:0]  snp_tag;
  logic [LINE_W-1:0] snp_line;
  logic              snp_hit;
  line_state_t       snp_state_nxt;
  logic              tag_we;
  logic [TAG_W-1:0]  tag_wr_tag;
  line_state_t       tag_wr_state;
  logic              line_we;
  logic [LINE_W-1:0] line_data;
  logic              word_we;
  logic [OFF_W-1:0]  word_off;
  logic [DATA_W-1:0] word_data;
  bus_cmd_t          fsm_cmd;
  logic              ev_hit;
  logic              ev_wb_wait;
  logic              ev_fill_wait;
  logic              ev_fill_done;

  assign snp_idx     = snp_addr[IDX_W-1:0];
  assign snp_tag_in  = snp_addr[LADDR_W-1 -: TAG_W];
  assign bus_req_cmd = fsm_cmd;

  msi_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) tags_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_idx(lk_idx), .cpu_state(lk_state), .cpu_tag(lk_tag),
    .snp_idx(snp_idx), .snp_state(snp_state), .snp_tag(snp_tag),
    .ctl_we(tag_we), .ctl_tag(tag_wr_tag), .ctl_state(tag_wr_state),
    .snp_we(snp_hit), .snp_state_nxt(snp_state_nxt)
  );

  msi_data_store #(.SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) data_i (
    .clk(clk),
    .cpu_idx(lk_idx), .cpu_line(lk_line),
    .snp_idx(snp_idx), .snp_line(snp_line),
    .line_we(line_we), .line_data(line_data),
    .word_we(word_we), .word_off(word_off), .word_data(word_data)
  );

  msi_snoop_unit #(.TAG_W(TAG_W), .LINE_W(LINE_W)) snoop_i (
    .snp_valid(snp_valid), .snp_cmd(bus_cmd_t'(snp_cmd)), .snp_tag_in(snp_tag_in),
    .line_state(snp_state), .line_tag(snp_tag), .line_data(snp_line),
    .snp_hit(snp_hit), .snp_state_nxt(snp_state_nxt),
    .flush(snp_flush), .flush_data(snp_flush_data)
  );

  msi_ctrl_fsm #(.ADDR_W(ADDR_W), .WORDS(WORDS), .SETS(SETS), .DATA_W(DATA_W)) fsm_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .snp_valid(snp_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_resp_valid(cpu_resp_valid), .cpu_resp_rdata(cpu_resp_rdata),
    .lk_idx(lk_idx), .lk_state(lk_state), .lk_tag(lk_tag), .lk_line(lk_line),
    .tag_we(tag_we), .tag_wr_tag(tag_wr_tag), .tag_wr_state(tag_wr_state),
    .line_we(line_we), .line_data(line_data),
    .word_we(word_we), .word_off(word_off), .word_data(word_data),
    .bus_req_valid(bus_req_valid), .bus_req_cmd(fsm_cmd),
    .bus_req_addr(bus_req_addr), .bus_req_data(bus_req_data),
    .bus_done(bus_done), .bus_rdata(bus_rdata),
    .ev_hit(ev_hit), .ev_wb_wait(ev_wb_wait),
    .ev_fill_wait(ev_fill_wait), .ev_fill_done(ev_fill_done)
  );

endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk #(
  parameter int LADDR_W = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_req_ready,
  input logic               cpu_resp_valid,
  input logic               bus_req_valid,
  input logic [1:0]         bus_req_cmd,
  input logic [LADDR_W-1:0] bus_req_addr,
  input logic               bus_done,
  input logic               snp_valid,
  input logic [1:0]         snp_cmd,
  input logic               snp_flush,
  input logic               ev_hit,
  input logic               ev_wb_wait,
  input logic               ev_fill_wait,
  input logic               ev_fill_done
);

  AST_IDLE_NO_BUS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_ready |-> !bus_req_valid); // R1

  AST_RESP_FOLLOWS_HIT_OR_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_resp_valid |-> ($past(ev_hit) || $past(ev_fill_done))); // R2

  AST_FLUSH_ONLY_ON_PEER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> (snp_valid && (snp_cmd == 2'd1 || snp_cmd == 2'd2))); // R6

  AST_WB_WAIT_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wb_wait && bus_req_valid) |-> (bus_req_cmd == 2'd3)); // R9

  AST_SNOOP_BLOCKS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !cpu_req_ready); // R11

  AST_FETCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fill_wait && !bus_done) |=> (ev_fill_wait && bus_req_valid &&
      $stable(bus_req_addr) && $stable(bus_req_cmd))); // R11

  AST_NO_SNOOP_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(snp_valid && bus_done)); // R11

endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk #(.LADDR_W(LADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .cpu_req_ready(cpu_req_ready), .cpu_resp_valid(cpu_resp_valid),
  .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd),
  .bus_req_addr(bus_req_addr), .bus_done(bus_done),
  .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_flush(snp_flush),
  .ev_hit(ev_hit), .ev_wb_wait(ev_wb_wait),
  .ev_fill_wait(ev_fill_wait), .ev_fill_done(ev_fill_done)
);

// File: tb/msi_snoop_ctrl_tb.sv
`timescale 1ns/1ps
module msi_snoop_ctrl_tb_top;

  localparam int ADDR_W  = 12;
  localparam int WORDS   = 4;
  localparam int SETS    = 8;
  localparam int DATA_W  = 32;
  localparam int OFF_W   = 2;
  localparam int IDX_W   = 3;
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
  localparam int LADDR_W = ADDR_W - OFF_W;
  localparam int LINE_W  = WORDS * DATA_W;
  localparam logic [1:0] S_I = 2'd0, S_S = 2'd1, S_M = 2'd2;
  localparam logic [1:0] C_RD = 2'd1, C_RDX = 2'd2, C_WB = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [ADDR_W-1:0] cpu_req_addr = '0;
  logic [DATA_W-1:0] cpu_req_wdata = '0;
  logic cpu_req_ready, cpu_resp_valid;
  logic [DATA_W-1:0] cpu_resp_rdata;
  logic bus_req_valid;
  logic [1:0] bus_req_cmd;
  logic [LADDR_W-1:0] bus_req_addr;
  logic [LINE_W-1:0] bus_req_data;
  logic bus_done = 1'b0;
  logic [LINE_W-1:0] bus_rdata = '0;
  logic snp_valid = 1'b0;
  logic [1:0] snp_cmd = '0;
  logic [LADDR_W-1:0] snp_addr = '0;
  logic snp_flush;
  logic [LINE_W-1:0] snp_flush_data;

  always #2.5 clk = ~clk;

  msi_snoop_ctrl dut_i (.*);

  // bench model
  logic [1:0]        m_state [SETS];
  logic [TAG_W-1:0]  m_tag   [SETS];
  logic [LINE_W-1:0] m_data  [SETS];
  logic [LINE_W-1:0] mem     [1 << LADDR_W];
  int n_tests = 0;
  int n_fail  = 0;

  function automatic logic [DATA_W-1:0] f_word(logic [LINE_W-1:0] l, int off);
    return l[off*DATA_W +: DATA_W];
  endfunction

  function automatic logic [LINE_W-1:0] f_merge(logic [LINE_W-1:0] l, int off, logic [DATA_W-1:0] w);
    logic [LINE_W-1:0] r;
    r = l;
    r[off*DATA_W +: DATA_W] = w;
    return r;
  endfunction

  function automatic logic f_is_hit(logic [1:0] st, logic wr);
    if (st == S_M) return 1'b1;
    return (st == S_S) && !wr;
  endfunction

  function automatic logic [1:0] f_after_snoop(logic [1:0] st, logic [1:0] cmd);
    if (cmd == C_RDX) return S_I;
    if (cmd == C_RD && st == S_M) return S_S;
    return st;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // caller is at a negedge
  task automatic do_snoop(input logic [1:0] cmd, input logic [LADDR_W-1:0] la);
    int idx;
    logic hitl, expf;
    string rq;
    idx  = int'(la[IDX_W-1:0]);
    hitl = (m_state[idx] != S_I) && (m_tag[idx] == la[LADDR_W-1 -: TAG_W]);
    expf = hitl && (m_state[idx] == S_M) && (cmd == C_RD || cmd == C_RDX);
    if (expf) rq = (cmd == C_RD) ? "R6" : "R7";
    else rq = "R8";
    snp_valid = 1'b1; snp_cmd = cmd; snp_addr = la;
    #1;
    chk(snp_flush == expf, rq, "snoop flush", LINE_W'(snp_flush), LINE_W'(expf));
    if (expf) chk(snp_flush_data == m_data[idx], rq, "flush data", snp_flush_data, m_data[idx]);
    chk(cpu_req_ready == 1'b0, "R11", "ready during snoop", LINE_W'(cpu_req_ready), '0);
    if (expf) mem[la] = m_data[idx];
    if (hitl) m_state[idx] = f_after_snoop(m_state[idx], cmd);
    if (cmd == C_RDX) mem[la] = f_merge(mem[la], int'($urandom % WORDS), $urandom);
    @(posedge clk); #1;
    snp_valid = 1'b0;
  endtask

  // mode 0: no snoop injection, 1: random, 2: peer read of the victim while write back waits
  task automatic cpu_op(input logic wr, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] wd, input int mode);
    int idx, off, cyc;
    logic [TAG_W-1:0] tg, vtag;
    logic hit, wb_pend, withdrawn, done, forced;
    logic [1:0] ecmd;
    logic [LADDR_W-1:0] eaddr;
    logic [DATA_W-1:0] exp_r;
    string rq;
    off = int'(a[OFF_W-1:0]);
    idx = int'(a[OFF_W +: IDX_W]);
    tg  = a[ADDR_W-1 -: TAG_W];
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = wd;
    #1;
    chk(cpu_req_ready == 1'b1, "R11", "ready when idle", LINE_W'(cpu_req_ready), 1);
    hit     = (m_tag[idx] == tg) && f_is_hit(m_state[idx], wr);
    wb_pend = (m_state[idx] == S_M) && (m_tag[idx] != tg);
    vtag    = m_tag[idx];
    withdrawn = 1'b0; forced = 1'b0; exp_r = '0;
    @(posedge clk); #1;
    cpu_req_valid = 1'b0;
    if (hit) begin
      rq = wr ? "R5" : "R2";
      exp_r = wr ? wd : f_word(m_data[idx], off);
      if (wr) m_data[idx] = f_merge(m_data[idx], off, wd);
      @(negedge clk);
      chk(cpu_resp_valid == 1'b1, rq, "hit response", LINE_W'(cpu_resp_valid), 1);
      chk(cpu_resp_rdata == exp_r, rq, "hit data", LINE_W'(cpu_resp_rdata), LINE_W'(exp_r));
      chk(bus_req_valid == 1'b0, rq, "no bus on hit", LINE_W'(bus_req_valid), 0);
      return;
    end
    done = 1'b0; cyc = 0;
    while (!done && cyc < 80) begin
      cyc++;
      @(negedge clk);
      if (cpu_resp_valid) begin
        rq = wr ? "R4" : "R3";
        chk(cpu_resp_rdata == exp_r, rq, "miss data", LINE_W'(cpu_resp_rdata), LINE_W'(exp_r));
        done = 1'b1;
      end else if (bus_req_valid) begin
        if (wb_pend && !(m_state[idx] == S_M && m_tag[idx] == vtag)) begin
          wb_pend = 1'b0; withdrawn = 1'b1;
        end
        if (wb_pend) begin
          ecmd = C_WB; eaddr = {vtag, IDX_W'(idx)}; rq = "R9";
        end else begin
          ecmd = wr ? C_RDX : C_RD; eaddr = {tg, IDX_W'(idx)};
          rq = withdrawn ? "R10" : (wr ? "R4" : "R3");
        end
        chk(bus_req_cmd == ecmd, rq, "bus cmd", LINE_W'(bus_req_cmd), LINE_W'(ecmd));
        chk(bus_req_addr == eaddr, rq, "bus addr", LINE_W'(bus_req_addr), LINE_W'(eaddr));
        if (ecmd == C_WB)
          chk(bus_req_data == m_data[idx], "R9", "wb data", bus_req_data, m_data[idx]);
        if (mode == 2 && ecmd == C_WB && !forced) begin
          forced = 1'b1;
          do_snoop(C_RD, eaddr);
        end else if (mode == 1 && ($urandom % 4) == 0) begin
          do_snoop(($urandom % 2) ? C_RDX : C_RD,
                   ($urandom % 2) ? eaddr : {TAG_W'($urandom % 3), IDX_W'(idx)});
        end else if (($urandom % 4) == 0) begin
          // bus busy: request must wait
        end else begin
          bus_done = 1'b1;
          bus_rdata = mem[eaddr];
          if (ecmd == C_WB) begin
            mem[eaddr] = m_data[idx];
            m_state[idx] = S_I;
            wb_pend = 1'b0;
          end else begin
            m_data[idx]  = wr ? f_merge(mem[eaddr], off, wd) : mem[eaddr];
            m_tag[idx]   = tg;
            m_state[idx] = wr ? S_M : S_S;
            exp_r = wr ? wd : f_word(mem[eaddr], off);
          end
          @(posedge clk); #1;
          bus_done = 1'b0;
        end
      end
    end
    if (!done) chk(1'b0, wr ? "R4" : "R3", "no response", 0, 1);
  endtask

  function automatic logic [ADDR_W-1:0] mk_addr(int t, int s, int o);
    return {TAG_W'(t), IDX_W'(s), OFF_W'(o)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    for (int l = 0; l < (1 << LADDR_W); l++)
      for (int w = 0; w < WORDS; w++)
        mem[l][w*DATA_W +: DATA_W] = 32'hA500_0000 ^ (l * 16 + w);
    for (int s = 0; s < SETS; s++) begin
      m_state[s] = S_I; m_tag[s] = '0; m_data[s] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_req_ready == 1'b1, "R1", "ready after reset", LINE_W'(cpu_req_ready), 1);
    chk(bus_req_valid == 1'b0, "R1", "no bus after reset", LINE_W'(bus_req_valid), 0);
    chk(cpu_resp_valid == 1'b0, "R1", "no resp after reset", LINE_W'(cpu_resp_valid), 0);
    chk(snp_flush == 1'b0, "R1", "no flush after reset", LINE_W'(snp_flush), 0);

    // R1 R3: cold read, then R2 read hit on Shared
    cpu_op(1'b0, mk_addr(0, 1, 2), '0, 0);
    cpu_op(1'b0, mk_addr(0, 1, 3), '0, 0);
    // R4: write to Shared still fetches for ownership; R5, R2 hits on Modified
    cpu_op(1'b1, mk_addr(0, 1, 0), 32'h1111_0001, 0);
    cpu_op(1'b0, mk_addr(0, 1, 0), '0, 0);
    cpu_op(1'b1, mk_addr(0, 1, 1), 32'h1111_0002, 0);
    // R6: peer read of Modified line, then write must upgrade again
    @(negedge clk); do_snoop(C_RD, {TAG_W'(0), IDX_W'(1)});
    cpu_op(1'b0, mk_addr(0, 1, 1), '0, 0);
    cpu_op(1'b1, mk_addr(0, 1, 2), 32'h2222_0003, 0);
    // R7: peer ownership request of Modified line, next read refetches
    @(negedge clk); do_snoop(C_RDX, {TAG_W'(0), IDX_W'(1)});
    cpu_op(1'b0, mk_addr(0, 1, 2), '0, 0);
    // R8: peer read keeps Shared, peer ownership drops it, misses and write backs ignored
    @(negedge clk); do_snoop(C_RD, {TAG_W'(0), IDX_W'(1)});
    cpu_op(1'b0, mk_addr(0, 1, 0), '0, 0);
    @(negedge clk); do_snoop(C_WB, {TAG_W'(0), IDX_W'(1)});
    @(negedge clk); do_snoop(C_RDX, {TAG_W'(5), IDX_W'(1)});
    cpu_op(1'b0, mk_addr(0, 1, 0), '0, 0);
    @(negedge clk); do_snoop(C_RDX, {TAG_W'(0), IDX_W'(1)});
    cpu_op(1'b0, mk_addr(0, 1, 3), '0, 0);
    // R9: Shared victim dropped silently, Modified victim written back first
    cpu_op(1'b1, mk_addr(1, 1, 3), 32'h3333_0004, 0);
    cpu_op(1'b0, mk_addr(0, 1, 1), '0, 0);
    // R10: victim downgraded by a peer read while its write back waits
    cpu_op(1'b1, mk_addr(2, 1, 0), 32'h4444_0005, 0);
    cpu_op(1'b0, mk_addr(1, 1, 3), '0, 2);
    cpu_op(1'b0, mk_addr(2, 1, 0), '0, 0);

    // constrained random mix
    for (int n = 0; n < 500; n++) begin
      int k;
      k = int'($urandom % 8);
      if (k < 6) begin
        cpu_op(($urandom % 5) < 2, mk_addr(int'($urandom % 3), int'($urandom % 4), int'($urandom % 4)),
               $urandom, 1);
      end else begin
        logic [1:0] c;
        c = ($urandom % 3 == 0) ? C_WB : (($urandom % 2) ? C_RD : C_RDX);
        @(negedge clk);
        do_snoop(c, {TAG_W'($urandom % 3), IDX_W'($urandom % 4)});
      end
    end

    // read back every touched line to confirm merged and fetched contents
    for (int s = 0; s < 4; s++)
      for (int t = 0; t < 3; t++)
        for (int o = 0; o < WORDS; o++)
          cpu_op(1'b0, mk_addr(t, s, o), '0, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule